// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block is the clock master of a digital audio bus. It runs entirely on the selected master clock, which is its only clock. It divides that clock down to a bit clock and a frame sync, and it also reports which time-slot pair the current bit belongs to. A 4-bit rate code picks the master-to-bit-clock ratio. A mode input picks one of two framing styles. In stereo mode the frame sync is a word select. In network mode it is a single-bit-clock pulse that opens a frame of one to four slot pairs.

Each of the two outputs has its own polarity control. The generator has its own run input, so it can supply clocks while the converter fed by the bus is switched off. Every control input is sampled only at a frame boundary, or at any cycle while the generator is stopped. A setting change therefore never produces a shortened bit-clock phase or a broken frame.

Top module: `aclk_gen`

## Requirements
- R1: While reset is asserted, and afterwards until the generator starts, `bclOut`, `fsOut` and `slotOut` are all 0 when both polarity inputs are 0.
- R2: Rate code 4'b1000 gives a bit clock of master/4: low for two master cycles, then high for two. Codes 4'b1001 and 4'b1010 give master/2: low for one master cycle, then high for one.
- R3: In stereo mode (`netMode`=0) a frame has 32 bits. The uninverted sync is low for bits 0..15 and high for bits 16..31. Every sync change coincides with a falling edge of the uninverted bit clock.
- R4: In network mode (`netMode`=1) a frame has 32×(`pairSel`+1) bits, with `pairSel` taking values 0..3. The uninverted sync is high only during bit 0 of each frame.
- R5: `slotOut` equals the bit index within the frame divided by 32 in network mode. It is 0 in stereo mode, whatever `pairSel` holds.
- R6: `bclInvert`=1 inverts the bit clock and `fsInvert`=1 inverts the sync. Both inversions also apply to the stopped (inactive) levels.
- R7: When `genOn`=0, or when the rate code is anything other than 4'b1000, 4'b1001 or 4'b1010, the generator stays stopped. Its outputs then sit at their inactive levels: `bclOut`=`bclInvert`, `fsOut`=`fsInvert`, `slotOut`=0.
- R8: From the stopped state, suppose a master edge samples `genOn`=1 with a valid code. The outputs still show the inactive levels after that edge. After the next edge they show bit 0, phase 0 of the first frame.
- R9: While running, changes to any control input (rate, mode, pair count, polarity, `genOn`) have no effect until the last master cycle of the current frame has completed. The next frame then uses the new settings in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| genOn | input | 1 | Run request for the generator |
| rateCode | input | 4 | Sample-rate code |
| netMode | input | 1 | 1 = network framing with short sync, 0 = stereo word select |
| pairSel | input | 2 | Slot pairs per network frame minus one |
| bclInvert | input | 1 | Invert bit clock |
| fsInvert | input | 1 | Invert frame sync |
| bclOut | output | 1 | Bit clock |
| fsOut | output | 1 | Frame sync / word select |
| slotOut | output | 2 | Index of the slot pair holding the current bit |

## Verification
The hardest state to reach is a control change landing mid-frame. At that moment the old framing must keep running unchanged until the frame's last master cycle, and the new one must begin cleanly on the very next cycle. The bench drives such changes a few bits into a frame: a switch of rate, mode, pair count and polarity all at once, and a drop of `genOn` during a later frame. It then compares every master cycle against an arithmetic waveform. That waveform is split at the predicted frame length of the old setting. A sweep over every valid code, both modes, all pair counts and all four polarity combinations covers the steady-state waveforms. A sweep over all reserved codes covers the stopped levels.

// File: rtl/aclk_pkg.sv
`timescale 1ns/1ps
package aclk_pkg;

  // Active configuration captured at a frame boundary
  typedef struct packed {
    logic       run;
    logic [1:0] divM1;   // master cycles per bit minus one
    logic       net;
    logic       bclInv;
    logic       fsInv;
  } clkCfg_t;

  // Strobes and settings passed from control to datapath
  typedef struct packed {
    logic run;
    logic load;      // frame boundary: restart bit count
    logic bitEnd;    // last master cycle of a bit
    logic bclHigh;   // uninverted bit-clock phase
    logic net;
    logic bclInv;
    logic fsInv;
  } ctrlStrobe_t;

  // Returns {valid, divM1} for a rate code
  function automatic logic [2:0] decodeRate(input logic [3:0] code);
    case (code)
      4'b1000: decodeRate = {1'b1, 2'd3};  // master / 4
      4'b1001: decodeRate = {1'b1, 2'd1};  // master / 2
      4'b1010: decodeRate = {1'b1, 2'd1};  // master / 2
      default: decodeRate = {1'b0, 2'd0};  // reserved: stopped
    endcase
  endfunction

endpackage

// File: rtl/aclk_ctrl.sv
`timescale 1ns/1ps
module aclk_ctrl
  import aclk_pkg::*;
#(
  parameter int PAIR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              genOn,
  input  logic [3:0]        rateCode,
  input  logic              netMode,
  input  logic [PAIR_W-1:0] pairSel,
  input  logic              bclInvert,
  input  logic              fsInvert,
  input  logic              frameLast,
  output logic [PAIR_W-1:0] pairsQ,
  output ctrlStrobe_t       strobe
);

  clkCfg_t    cfgQ;
  clkCfg_t    nextCfg;
  logic [1:0] divCnt;
  logic [2:0] rateDec;
  logic       lastDiv;
  logic       bitEnd;
  logic       load;

  always_comb begin
    rateDec        = decodeRate(rateCode);
    nextCfg.run    = genOn & rateDec[2];
    nextCfg.divM1  = rateDec[1:0];
    nextCfg.net    = netMode;
    nextCfg.bclInv = bclInvert;
    nextCfg.fsInv  = fsInvert;
  end

  assign lastDiv = (divCnt == cfgQ.divM1);
  assign bitEnd  = cfgQ.run & lastDiv;
  // Settings are taken while stopped, or after the final cycle of a frame
  assign load    = ~cfgQ.run | (bitEnd & frameLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ   <= '0;
      pairsQ <= '0;
      divCnt <= '0;
    end else if (load) begin
      cfgQ   <= nextCfg;
      pairsQ <= pairSel;
      divCnt <= '0;
    end else if (lastDiv) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 2'd1;
    end
  end

  always_comb begin
    strobe.run     = cfgQ.run;
    strobe.load    = load;
    strobe.bitEnd  = bitEnd;
    strobe.bclHigh = (divCnt > (cfgQ.divM1 >> 1));
    strobe.net     = cfgQ.net;
    strobe.bclInv  = cfgQ.bclInv;
    strobe.fsInv   = cfgQ.fsInv;
  end

  // R2: phase counter never passes the decoded ratio
  p_div_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.run |-> (divCnt <= cfgQ.divM1));

  // R9: settings hold for the whole frame
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.run && !load) |=> ($stable(cfgQ) && $stable(pairsQ)));

endmodule

// File: rtl/aclk_dp.sv
`timescale 1ns/1ps
module aclk_dp
  import aclk_pkg::*;
#(
  parameter  int SLOT_BITS = 16,
  parameter  int MAX_PAIRS = 4,
  localparam int PAIR_W    = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1,
  localparam int PAIR_BITS = 2 * SLOT_BITS,
  localparam int FRAME_MAX = PAIR_BITS * MAX_PAIRS,
  localparam int CNT_W     = $clog2(FRAME_MAX),
  localparam int SLOT_SH   = $clog2(PAIR_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [PAIR_W-1:0] pairsQ,
  output logic              frameLast,
  output logic              bclOut,
  output logic              fsOut,
  output logic [PAIR_W-1:0] slotOut
);

  logic [CNT_W-1:0]  bitCnt;
  logic [CNT_W:0]    frameLen;
  logic              fsRaw;
  logic [PAIR_W-1:0] slotRaw;

  always_comb begin
    frameLen  = strobe.net ? (CNT_W+1)'(PAIR_BITS * (int'(pairsQ) + 1))
                           : (CNT_W+1)'(PAIR_BITS);
    frameLast = ({1'b0, bitCnt} == (frameLen - 1'b1));
    fsRaw     = strobe.net ? (bitCnt == '0) : (bitCnt >= CNT_W'(SLOT_BITS));
    slotRaw   = strobe.net ? PAIR_W'(bitCnt >> SLOT_SH) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      bclOut  <= 1'b0;
      fsOut   <= 1'b0;
      slotOut <= '0;
    end else begin
      if (strobe.load)        bitCnt <= '0;
      else if (strobe.bitEnd) bitCnt <= bitCnt + 1'b1;
      bclOut  <= strobe.run ? (strobe.bclHigh ^ strobe.bclInv) : strobe.bclInv;
      fsOut   <= strobe.run ? (fsRaw ^ strobe.fsInv) : strobe.fsInv;
      slotOut <= strobe.run ? slotRaw : '0;
    end
  end

  // R3: the bit index wraps to zero after the last bit of a frame
  p_frame_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bitEnd && frameLast) |=> (bitCnt == '0));

  // R5: slot index stays within the configured pair count
  p_slot_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && strobe.net) |-> (slotRaw <= pairsQ));

  // R7: a stopped generator presents no slot index
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |=> (slotOut == '0));

endmodule

// File: rtl/aclk_gen.sv
`timescale 1ns/1ps
module aclk_gen
  import aclk_pkg::*;
#(
  parameter  int SLOT_BITS = 16,
  parameter  int MAX_PAIRS = 4,
  localparam int PAIR_W    = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              genOn,
  input  logic [3:0]        rateCode,
  input  logic              netMode,
  input  logic [PAIR_W-1:0] pairSel,
  input  logic              bclInvert,
  input  logic              fsInvert,
  output logic              bclOut,
  output logic              fsOut,
  output logic [PAIR_W-1:0] slotOut
);

  ctrlStrobe_t       strobe;
  logic [PAIR_W-1:0] pairsQ;
  logic              frameLast;

  aclk_ctrl #(.PAIR_W(PAIR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .genOn     (genOn),
    .rateCode  (rateCode),
    .netMode   (netMode),
    .pairSel   (pairSel),
    .bclInvert (bclInvert),
    .fsInvert  (fsInvert),
    .frameLast (frameLast),
    .pairsQ    (pairsQ),
    .strobe    (strobe)
  );

  aclk_dp #(.SLOT_BITS(SLOT_BITS), .MAX_PAIRS(MAX_PAIRS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pairsQ    (pairsQ),
    .frameLast (frameLast),
    .bclOut    (bclOut),
    .fsOut     (fsOut),
    .slotOut   (slotOut)
  );

endmodule

// File: tb/sim_aclk_gen.sv
`timescale 1ns/1ps
module sim_aclk_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       genOn = 1'b0;
  logic [3:0] rateCode = 4'd0;
  logic       netMode = 1'b0;
  logic [1:0] pairSel = 2'd0;
  logic       bclInvert = 1'b0;
  logic       fsInvert = 1'b0;
  logic       bclOut, fsOut;
  logic [1:0] slotOut;

  int nChk = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  aclk_gen u0 (
    .clk(clk), .rstN(rstN), .genOn(genOn), .rateCode(rateCode),
    .netMode(netMode), .pairSel(pairSel), .bclInvert(bclInvert),
    .fsInvert(fsInvert), .bclOut(bclOut), .fsOut(fsOut), .slotOut(slotOut)
  );

  function automatic int divOf(input int code);
    return (code == 8) ? 4 : 2;
  endfunction

  function automatic int frameBits(input int net, input int pairs);
    return net ? 32 * (pairs + 1) : 32;
  endfunction

  function automatic int frameCycles(input int code, input int net, input int pairs);
    return divOf(code) * frameBits(net, pairs);
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chkSlot(input logic [1:0] exp, input string tag);
    nChk++;
    if (slotOut !== exp) begin
      nErr++;
      $display("FAIL %s slot: actual %0d expected %0d at %0t", tag, slotOut, exp, $time);
    end
  endtask

  task automatic chkIdle(input logic bi, input logic fi, input string tag);
    chk(bclOut, bi, tag, "idle bcl");
    chk(fsOut, fi, tag, "idle fs");
    chkSlot(2'd0, tag);
  endtask

  // Expected output for master cycle n of a running segment
  task automatic chkRun(input int code, input int net, input int pairs,
                        input logic bi, input logic fi, input int n);
    int div, bitIdx, phase;
    logic eb, ef;
    logic [1:0] es;
    div    = divOf(code);
    phase  = n % div;
    bitIdx = (n / div) % frameBits(net, pairs);
    eb = ((phase >= div / 2) ? 1'b1 : 1'b0) ^ bi;
    ef = (net ? (bitIdx == 0) : (bitIdx >= 16)) ^ fi;
    es = net ? 2'(bitIdx / 32) : 2'd0;
    chk(bclOut, eb, bi ? "R6" : "R2", "bcl");
    chk(fsOut, ef, fi ? "R6" : (net ? "R4" : "R3"), "fs");
    chkSlot(es, "R5");
  endtask

  // Generator must be stopped on entry; leaves it running with edge E0 passed
  task automatic startRun(input int code, input int net, input int pairs,
                          input logic bi, input logic fi);
    @(negedge clk);
    genOn = 1'b0; rateCode = 4'(code); netMode = net[0]; pairSel = 2'(pairs);
    bclInvert = bi; fsInvert = fi;
    repeat (2) @(negedge clk);
    genOn = 1'b1;
    @(negedge clk);
    chkIdle(bi, fi, "R8");  // first sampling edge still shows stopped levels
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chkIdle(1'b0, 1'b0, "R1");
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chkIdle(1'b0, 1'b0, "R1");

    // Sweep: every valid code, both modes, all pair counts, all polarities.
    // genOn drops mid second frame; R9 stop lands at the frame end.
    for (int code = 8; code <= 10; code++)
      for (int net = 0; net < 2; net++)
        for (int pairs = 0; pairs < 4; pairs++)
          for (int pol = 0; pol < 4; pol++) begin
            int fc;
            fc = frameCycles(code, net, pairs);
            startRun(code, net, pairs, pol[0], pol[1]);
            for (int n = 0; n < 2 * fc + 3; n++) begin
              @(negedge clk);
              if (n < 2 * fc) chkRun(code, net, pairs, pol[0], pol[1], n);
              else chkIdle(pol[0], pol[1], "R9");
              if (n == fc + 5) genOn = 1'b0;
            end
          end

    // R9: mid-frame change of rate, mode, pairs and polarity together
    begin
      int fcOld, fcNew;
      fcOld = frameCycles(8, 0, 0);
      fcNew = frameCycles(9, 1, 1);
      startRun(8, 0, 0, 1'b0, 1'b0);
      for (int n = 0; n < fcOld + fcNew + 10; n++) begin
        @(negedge clk);
        if (n < fcOld) chkRun(8, 0, 0, 1'b0, 1'b0, n);
        else           chkRun(9, 1, 1, 1'b1, 1'b0, n - fcOld);
        if (n == 10) begin
          rateCode = 4'b1001; netMode = 1'b1; pairSel = 2'd1; bclInvert = 1'b1;
        end
        if (n == fcOld + fcNew + 2) genOn = 1'b0;
      end
      repeat (fcNew + 4) @(negedge clk);
      chkIdle(1'b1, 1'b0, "R9");
    end

    // R7: every reserved code keeps the generator stopped
    for (int code = 0; code < 16; code++) begin
      if (code < 8 || code > 10) begin
        @(negedge clk);
        rateCode = 4'(code); genOn = 1'b1; netMode = code[2];
        bclInvert = code[0]; fsInvert = code[1];
        repeat (2) @(negedge clk);
        for (int k = 0; k < 6; k++) begin
          @(negedge clk);
          chkIdle(code[0], code[1], "R7");
        end
      end
    end

    // R7: valid code with genOn low stays stopped
    @(negedge clk);
    genOn = 1'b0; rateCode = 4'b1000; bclInvert = 1'b1; fsInvert = 1'b1;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chkIdle(1'b1, 1'b1, "R7");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nErr);
      $finish;
    end
  end

endmodule